// File: doc/BRIEF.md
# ATM Cell Boundary Finder

This block locates ATM cell boundaries in a stream of byte-aligned payload words, using the check byte that closes each cell header. Each accepted word carries four bytes. The most significant byte comes first in time. A 53-byte cell does not fill a whole number of words, so its first byte moves by one lane from one cell to the next. While searching, the block tests every byte offset of the held word at the same time. Once it has a boundary, it tests only the lane where the next header is due.

A confidence machine has three states: searching, tentative and locked. It moves between them on runs of good and bad header checks. The run lengths are set by two threshold inputs. Cells leave the block only while it is locked. Each cell leaves as 53 consecutive enabled byte lanes, with a start-of-cell flag on the first byte. An optional self-synchronising descrambler with a 43-bit span can recover the 48 payload bytes. Header bytes are never descrambled.

Top module: `atm_cell_delineator`

## Requirements
- R1: During and after synchronous reset, `sync_state` is 0 (searching), `in_sync` is 0, `out_valid` is 0, and no lane or start flag is set.
- R2: A 5-byte candidate header is valid when its fifth byte equals the CRC-8 of its first four bytes, XORed with 0x55. The CRC uses generator x^8+x^2+x+1, starts from zero and takes the bits most significant first.
- R3: While searching, each accepted word is paired with the word held before it. A candidate header starting at each of the four byte offsets of the held word is checked. The lowest valid offset fixes the boundary, and `sync_state` becomes 1 (tentative) on the edge that accepts the word holding that header's fifth byte.
- R4: In the tentative state, `delta_thr` consecutive valid checks at the fixed boundary move the state to 2 (locked). A delta of 0 acts as 1. A single invalid check returns the state to searching. The searching state never goes straight to locked.
- R5: In the locked state, `alpha_thr` consecutive invalid checks return the state to searching. A valid check clears the run. An alpha of 0 acts as 1.
- R6: A cell is delivered only when the state after its own header check is locked. A delivered cell appears as exactly 53 enabled output lanes, in order, with `out_soc` set only on its first byte. No lanes are enabled after a searching-state cycle.
- R7: When `desc_en` is 1, each of the 48 payload bytes is descrambled as d = s XOR (the received payload bit 43 positions earlier). Header bytes pass unchanged and do not advance the descrambler. The descrambler advances only outside the searching state. When `desc_en` is 0, payload bytes pass unchanged.
- R8: A cycle with `in_valid` low changes no state, counter or alignment, and produces `out_valid` low on the following cycle.
- R9: `sync_state` encodes searching=0, tentative=1, locked=2, and never shows 3. `in_sync` is 1 exactly when the state is locked. Output lane 0 is bits 31:24 and comes first in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 32 | Payload word, first byte in bits 31:24 |
| desc_en | input | 1 | Enable payload descrambling |
| alpha_thr | input | 4 | Invalid checks needed to leave the locked state |
| delta_thr | input | 4 | Valid checks needed to reach the locked state |
| out_valid | output | 1 | Output word strobe, one cycle after each paired input word |
| out_data | output | 32 | Output word, payload lanes descrambled when enabled |
| out_lane_en | output | 4 | Lanes carrying bytes of a delivered cell |
| out_soc | output | 4 | Lane carrying the first byte of a delivered cell |
| sync_state | output | 2 | Current confidence state |
| in_sync | output | 1 | High while locked |

## Verification
If the block records the wrong boundary, its next check fails within one cell time, about 14 words. The failure shows as a state drop on `sync_state` at the word holding the expected check byte. A position counter that slips shows up as delivered cells whose start flag is not 53 lanes after the previous one, or whose header bytes do not match the ones sent. A stale or wrongly advanced descrambler history corrupts payload bytes of the first delivered cell, and this is visible on `out_data`. The bench therefore samples `sync_state` right after the exact words that complete chosen headers. It also compares every delivered cell, byte by byte, with the sent stream.

// File: rtl/celldl_pkg.sv
package celldl_pkg;

    localparam int CELL_BYTES = 53;
    localparam int HDR_BYTES  = 5;
    localparam int SCR_LEN    = 43;
    localparam logic [7:0] HEC_POLY  = 8'h07;
    localparam logic [7:0] HEC_COSET = 8'h55;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PRESYNC = 2'd1,
        ST_SYNC    = 2'd2
    } dl_state_e;

    typedef struct packed {
        logic [SCR_LEN-1:0] hist;
        logic [7:0]         data;
    } x43_res_t;

    // header check value: CRC-8 over 32 bits, MSB first, with coset added
    function automatic logic [7:0] hec_of(input logic [31:0] hdr);
        logic [7:0] crc;
        logic       fb;
        crc = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            fb  = crc[7] ^ hdr[i];
            crc = {crc[6:0], 1'b0};
            if (fb) crc = crc ^ HEC_POLY;
        end
        return crc ^ HEC_COSET;
    endfunction

    // self-synchronising descramble of one byte, MSB first
    function automatic x43_res_t x43_byte(input logic [SCR_LEN-1:0] hist,
                                          input logic [7:0] s);
        x43_res_t r;
        r.hist = hist;
        r.data = 8'h00;
        for (int b = 7; b >= 0; b--) begin
            r.data[b] = s[b] ^ r.hist[SCR_LEN-1];
            r.hist    = {r.hist[SCR_LEN-2:0], s[b]};
        end
        return r;
    endfunction

endpackage

// File: rtl/celldl_hec_bank.sv
module celldl_hec_bank
    import celldl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [16*LANES-1:0] window,
    output logic [LANES-1:0]    hit
);
    localparam int WW = 16 * LANES;

    for (genvar k = 0; k < LANES; k++) begin : g_off
        localparam int TOP = WW - 1 - 8 * k;
        logic [31:0] cand_hdr;
        logic [7:0]  cand_chk;
        assign cand_hdr = window[TOP -: 32];
        assign cand_chk = window[TOP-32 -: 8];
        assign hit[k]   = (hec_of(cand_hdr) == cand_chk);
    end

endmodule

// File: rtl/celldl_fsm.sv
module celldl_fsm
    import celldl_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [LANES-1:0] hit,
    input  logic [CNT_W-1:0] alpha_thr,
    input  logic [CNT_W-1:0] delta_thr,
    output dl_state_e        state,
    output logic [LANES-1:0] lane_pass,
    output logic [LANES-1:0] lane_soc,
    output logic [LANES-1:0] lane_pay
);
    localparam int POS_W = $clog2(CELL_BYTES);

    dl_state_e        state_q, nstate;
    logic [POS_W-1:0] pos_q, npos;
    logic [CNT_W-1:0] cnt_q, ncnt;
    logic             pass_q, npass;
    logic [LANES-1:0] hdr;
    logic             checking, good, found;
    logic [CNT_W:0]   cnt_inc;
    int               ksel, lp, p4;

    always_comb begin
        hdr      = '0;
        lane_pay = '0;
        for (int k = 0; k < LANES; k++) begin
            lp = int'(pos_q) + k;
            if (lp >= CELL_BYTES) lp = lp - CELL_BYTES;
            hdr[k]      = (state_q != ST_HUNT) && (lp == 0);
            lane_pay[k] = (state_q != ST_HUNT) && (lp >= HDR_BYTES);
        end
        checking = |hdr;
        good     = |(hdr & hit);

        found = 1'b0;
        ksel  = 0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (hit[k]) begin
                found = 1'b1;
                ksel  = k;
            end
        end

        p4 = int'(pos_q) + LANES;
        if (p4 >= CELL_BYTES) p4 = p4 - CELL_BYTES;

        cnt_inc = {1'b0, cnt_q} + 1'b1;
        nstate  = state_q;
        ncnt    = cnt_q;
        npos    = POS_W'(p4);
        unique case (state_q)
            ST_HUNT: begin
                npos = '0;
                ncnt = '0;
                if (found) begin
                    nstate = ST_PRESYNC;
                    npos   = POS_W'(LANES - ksel);
                end
            end
            ST_PRESYNC: begin
                if (checking) begin
                    if (!good) begin
                        nstate = ST_HUNT;
                        ncnt   = '0;
                    end else if (cnt_inc >= {1'b0, delta_thr}) begin
                        nstate = ST_SYNC;
                        ncnt   = '0;
                    end else begin
                        ncnt = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            ST_SYNC: begin
                if (checking) begin
                    if (good) begin
                        ncnt = '0;
                    end else if (cnt_inc >= {1'b0, alpha_thr}) begin
                        nstate = ST_HUNT;
                        ncnt   = '0;
                    end else begin
                        ncnt = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            default: begin
                nstate = ST_HUNT;
                ncnt   = '0;
            end
        endcase

        // pass decision changes at the lane where a header starts
        npass = pass_q;
        for (int k = 0; k < LANES; k++) begin
            if (hdr[k]) npass = (nstate == ST_SYNC);
            lane_pass[k] = npass;
        end
        if (nstate == ST_HUNT) npass = 1'b0;
        lane_soc = hdr & lane_pass;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            cnt_q   <= '0;
            pass_q  <= 1'b0;
        end else if (step) begin
            state_q <= nstate;
            pos_q   <= npos;
            cnt_q   <= ncnt;
            pass_q  <= npass;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/celldl_x43.sv
module celldl_x43
    import celldl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic               en,
    input  logic [LANES-1:0]   lane_pay,
    input  logic [8*LANES-1:0] din,
    output logic [8*LANES-1:0] dout
);
    localparam int DW = 8 * LANES;

    logic [SCR_LEN-1:0] hist_q, hist_n;
    x43_res_t           res;

    always_comb begin
        hist_n = hist_q;
        dout   = din;
        res    = '0;
        for (int k = 0; k < LANES; k++) begin
            if (en && lane_pay[k]) begin
                res = x43_byte(hist_n, din[DW-1-8*k -: 8]);
                hist_n = res.hist;
                dout[DW-1-8*k -: 8] = res.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       hist_q <= '0;
        else if (step) hist_q <= hist_n;
    end

endmodule

// File: rtl/atm_cell_delineator.sv
module atm_cell_delineator
    import celldl_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [8*LANES-1:0] in_data,
    input  logic               desc_en,
    input  logic [CNT_W-1:0]   alpha_thr,
    input  logic [CNT_W-1:0]   delta_thr,
    output logic               out_valid,
    output logic [8*LANES-1:0] out_data,
    output logic [LANES-1:0]   out_lane_en,
    output logic [LANES-1:0]   out_soc,
    output logic [1:0]         sync_state,
    output logic               in_sync
);
    localparam int DW = 8 * LANES;

    logic [DW-1:0]    w_q;
    logic             have_q;
    logic             step;
    logic [LANES-1:0] hit, lane_pass, lane_soc, lane_pay;
    logic [DW-1:0]    desc_data;
    dl_state_e        state;

    assign step = in_valid && have_q;

    celldl_hec_bank #(.LANES(LANES)) u_hec (
        .window ({w_q, in_data}),
        .hit    (hit)
    );

    celldl_fsm #(.LANES(LANES), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .hit       (hit),
        .alpha_thr (alpha_thr),
        .delta_thr (delta_thr),
        .state     (state),
        .lane_pass (lane_pass),
        .lane_soc  (lane_soc),
        .lane_pay  (lane_pay)
    );

    celldl_x43 #(.LANES(LANES)) u_x43 (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .en       (desc_en),
        .lane_pay (lane_pay),
        .din      (w_q),
        .dout     (desc_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q         <= '0;
            have_q      <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_lane_en <= '0;
            out_soc     <= '0;
        end else begin
            if (in_valid) begin
                w_q    <= in_data;
                have_q <= 1'b1;
            end
            out_valid   <= step;
            out_lane_en <= step ? lane_pass : '0;
            out_soc     <= step ? lane_soc  : '0;
            if (step) out_data <= desc_data;
        end
    end

    assign sync_state = state;
    assign in_sync    = (state == ST_SYNC);

endmodule

// File: rtl/celldl_checker.sv
module celldl_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [LANES-1:0] out_lane_en,
    input logic [LANES-1:0] out_soc,
    input logic [1:0]       sync_state
);
    AST_STALL_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(sync_state)); // R8
    AST_STALL_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8
    AST_HUNT_NOT_TO_SYNC: assert property (@(posedge clk) disable iff (rst)
        (sync_state == 2'd0) |=> (sync_state != 2'd2)); // R4
    AST_HUNT_NO_LANES: assert property (@(posedge clk) disable iff (rst)
        (sync_state == 2'd0) |=> (out_lane_en == '0)); // R6
    AST_LANES_NEED_SYNC: assert property (@(posedge clk) disable iff (rst)
        (|out_lane_en) |-> (sync_state == 2'd2 || $past(sync_state) == 2'd2)); // R6
    AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_soc)); // R6
    AST_SOC_IN_LANE: assert property (@(posedge clk) disable iff (rst)
        (out_soc & ~out_lane_en) == '0); // R6
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        sync_state != 2'd3); // R9
endmodule

bind atm_cell_delineator celldl_checker #(.LANES(LANES)) u_celldl_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_lane_en (out_lane_en),
    .out_soc     (out_soc),
    .sync_state  (sync_state)
);

// File: tb/test_atm_cell_delineator.sv
module test_atm_cell_delineator;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_data;
    logic        desc_en;
    logic [3:0]  alpha_thr, delta_thr;
    logic        out_valid;
    logic [31:0] out_data;
    logic [3:0]  out_lane_en, out_soc;
    logic [1:0]  sync_state;
    logic        in_sync;

    always #5 clk = ~clk;

    atm_cell_delineator i_atm_cell_delineator (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .desc_en(desc_en), .alpha_thr(alpha_thr), .delta_thr(delta_thr),
        .out_valid(out_valid), .out_data(out_data), .out_lane_en(out_lane_en),
        .out_soc(out_soc), .sync_state(sync_state), .in_sync(in_sync)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] strm[$];
    logic [7:0] cap_b[$];
    logic       cap_s[$];
    int wp  = 0;
    int gap = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] b_hec(input logic [31:0] h);
        logic [7:0] c = 8'h00;
        logic fb;
        for (int i = 31; i >= 0; i--) begin
            fb = c[7] ^ h[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c ^ 8'h55;
    endfunction

    function automatic logic [7:0] pay(input int c, input int j);
        return 8'((c * 29 + j * 7 + 3) & 255);
    endfunction

    function automatic int hec_idx(input int lead, input int c);
        return lead + 53 * c + 4;
    endfunction

    // collect delivered lanes in time order (lane 0 first, R9)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            for (int k = 0; k < 4; k++) begin
                if (out_lane_en[k]) begin
                    cap_b.push_back(out_data[31-8*k -: 8]);
                    cap_s.push_back(out_soc[k]);
                end
            end
        end
    end

    task automatic build(input int lead, input int ncells, input logic [63:0] bad,
                         input bit scr, input bit zpay);
        logic [42:0] sc = 43'h5A5A5A5A5A5;
        logic [31:0] h;
        logic [7:0]  e, p, s;
        strm.delete();
        for (int i = 0; i < lead; i++) strm.push_back(8'h00);
        for (int c = 0; c < ncells; c++) begin
            h = {24'h0, 8'(c + 1)};
            e = b_hec(h) ^ (bad[c] ? 8'h01 : 8'h00);
            for (int i = 3; i >= 0; i--) strm.push_back(h[8*i +: 8]);
            strm.push_back(e);
            for (int j = 0; j < 48; j++) begin
                p = zpay ? 8'h00 : pay(c, j);
                s = p;
                if (scr) begin
                    for (int b = 7; b >= 0; b--) begin
                        s[b] = p[b] ^ sc[42];
                        sc   = {sc[41:0], s[b]};
                    end
                end
                strm.push_back(s);
            end
        end
    endtask

    function automatic logic [7:0] byte_at(input int i);
        return (i < strm.size()) ? strm[i] : 8'h00;
    endfunction

    task automatic do_reset(input int a, input int d, input bit en);
        rst = 1'b1; in_valid = 1'b0; in_data = '0;
        alpha_thr = 4'(a); delta_thr = 4'(d); desc_en = en;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cap_b.delete(); cap_s.delete();
        wp = 0; gap = 0;
    endtask

    task automatic send_word();
        in_valid = 1'b1;
        in_data  = {byte_at(wp*4), byte_at(wp*4+1), byte_at(wp*4+2), byte_at(wp*4+3)};
        @(negedge clk);
        in_valid = 1'b0;
        wp++;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_through(input int idx);
        while (wp * 4 <= idx) send_word();
    endtask

    task automatic analyse(input int lead, input bit plain, output int first,
                           output int ncell, output int nbad);
        int idx = 0, prev = 0, id, start;
        logic [7:0] ex;
        first = -1; ncell = 0; nbad = 0;
        while (idx + 53 <= cap_b.size()) begin
            if (!cap_s[idx]) begin nbad++; break; end
            for (int i = 1; i < 53; i++) if (cap_s[idx+i]) nbad++;
            id = int'(cap_b[idx+3]);
            if (first < 0) first = id;
            else if (id != prev + 1) nbad++;
            prev  = id;
            start = lead + 53 * (id - 1);
            if (id < 1 || start + 53 > strm.size()) begin nbad++; break; end
            for (int i = 0; i < 53; i++) begin
                ex = (plain && i >= 5) ? pay(id - 1, i - 5) : strm[start+i];
                if (cap_b[idx+i] != ex) nbad++;
            end
            ncell++;
            idx += 53;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_data = '0; desc_en = 1'b0;
        alpha_thr = 4'd3; delta_thr = 4'd2;
        repeat (3) @(negedge clk);
        chk(sync_state == 2'd0, "R1 state", sync_state, 0);
        chk(in_sync == 1'b0, "R1 in_sync", in_sync, 0);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(out_lane_en == 4'd0, "R1 lanes", out_lane_en, 0);
    endtask

    task automatic t_offset(input int off);
        int lead = 8 + off, f, n, b;
        do_reset(3, 2, 1'b0);
        build(lead, 8, 64'd0, 1'b0, 1'b0);
        send_through(hec_idx(lead, 0) - 4);
        chk(sync_state == 2'd0, "R3 before header", sync_state, 0);
        send_through(hec_idx(lead, 0));
        chk(sync_state == 2'd1, "R3 lock at offset", sync_state, 1);
        send_through(hec_idx(lead, 1));
        chk(sync_state == 2'd1, "R4 one of two", sync_state, 1);
        send_through(hec_idx(lead, 2));
        chk(sync_state == 2'd2, "R4 delta reached", sync_state, 2);
        chk(in_sync == 1'b1, "R9 in_sync", in_sync, 1);
        send_through(strm.size() + 7);
        analyse(lead, 1'b0, f, n, b);
        chk(f == 3, "R6 first delivered", f, 3);
        chk(n >= 6, "R6 cell count", n, 6);
        chk(b == 0, "R2 R6 cell content", b, 0);
    endtask

    task automatic t_delta(input int d, input int exp_first);
        int f, n, b;
        do_reset(3, d, 1'b0);
        build(5, 6, 64'd0, 1'b0, 1'b0);
        send_through(strm.size() + 7);
        analyse(5, 1'b0, f, n, b);
        chk(f == exp_first, "R4 delta setting", f, exp_first);
        chk(b == 0, "R6 content", b, 0);
    endtask

    task automatic t_presync_fail();
        int lead = 6, f, n, b;
        do_reset(3, 3, 1'b0);
        build(lead, 12, 64'h2, 1'b0, 1'b1);
        send_through(hec_idx(lead, 0));
        chk(sync_state == 2'd1, "R3 lock", sync_state, 1);
        send_through(hec_idx(lead, 1));
        chk(sync_state == 2'd0, "R4 miss in presync", sync_state, 0);
        send_through(strm.size() + 7);
        chk(in_sync == 1'b1, "R4 relock", in_sync, 1);
        analyse(lead, 1'b0, f, n, b);
        chk(b == 0, "R6 content after relock", b, 0);
    endtask

    task automatic t_alpha();
        int lead = 4;
        do_reset(3, 1, 1'b0);
        build(lead, 14, 64'h3B0, 1'b0, 1'b1);   // bad cells 4,5,7,8,9
        send_through(hec_idx(lead, 1));
        chk(sync_state == 2'd2, "R4 delta one", sync_state, 2);
        send_through(hec_idx(lead, 5));
        chk(sync_state == 2'd2, "R5 two misses", sync_state, 2);
        send_through(hec_idx(lead, 6));
        chk(sync_state == 2'd2, "R5 good clears", sync_state, 2);
        send_through(hec_idx(lead, 8));
        chk(sync_state == 2'd2, "R5 run restarted", sync_state, 2);
        send_through(hec_idx(lead, 9));
        chk(sync_state == 2'd0, "R5 alpha reached", sync_state, 0);
        chk(in_sync == 1'b0, "R9 in_sync low", in_sync, 0);
    endtask

    task automatic t_descr(input bit en);
        int lead = 7, f, n, b;
        do_reset(3, 2, en);
        build(lead, 10, 64'd0, 1'b1, 1'b0);
        send_through(strm.size() + 7);
        analyse(lead, en, f, n, b);
        chk(f == 3, "R7 first delivered", f, 3);
        chk(n >= 7, "R7 cell count", n, 7);
        chk(b == 0, "R7 payload bytes", b, 0);
    endtask

    task automatic t_stall();
        int lead = 9, f, n, b;
        do_reset(3, 2, 1'b0);
        build(lead, 8, 64'd0, 1'b0, 1'b0);
        gap = 2;
        send_through(hec_idx(lead, 0));
        chk(sync_state == 2'd1, "R8 lock with gaps", sync_state, 1);
        repeat (5) @(negedge clk);
        chk(sync_state == 2'd1, "R8 state held", sync_state, 1);
        chk(out_valid == 1'b0, "R8 no output", out_valid, 0);
        send_through(strm.size() + 7);
        analyse(lead, 1'b0, f, n, b);
        chk(f == 3, "R8 first delivered", f, 3);
        chk(b == 0, "R8 content", b, 0);
    endtask

    initial begin
        #(150000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        for (int o = 0; o < 4; o++) t_offset(o);
        t_delta(1, 2);
        t_delta(0, 2);
        t_delta(4, 5);
        t_presync_fail();
        t_alpha();
        t_descr(1'b1);
        t_descr(1'b0);
        t_stall();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule